// File: doc/BRIEF.md
# Two-Channel DAC Serial Command Front End

This block is the digital front end of a two-channel, 16-bit digital-to-analog converter controller. A host shifts 32-bit command frames into it over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block decodes each frame and updates its register state. Each channel has two registers in series. The input register is a staging register. The DAC register holds the code that the converter core drives. Frames carry a command field, a channel address and a 16-bit straight-binary code. Code 0 means zero output and code 65535 means full scale.

The command set covers the following operations. A staged write. A transfer from the input register to the DAC register. A write that also loads every channel. A direct write-and-load. Per-channel power-down flags. A clear-code register. A load mask that turns staged writes into immediate ones. A software reset. A daisy-chain mode, in which the bits leaving the shift register appear on a serial output so that several devices can share one frame select.

All serial pins are sampled by the system clock, which must run well above the serial clock rate. A frame is acted on by the system clock: there is no separate clock domain for the serial link.

Top module: `dacif_top`

## Requirements
- R1: Frames are shifted in MSB first on falling serial-clock edges while frame select is low. Frame bits 27:24 hold the command, bits 23:20 hold the address, and bits 19:4 hold the 16-bit code. Bits 31:28 and 3:0 are ignored. In normal mode a frame takes effect on the 32nd falling edge, and the outputs show the result two system clocks after that edge is sampled.
- R2: If frame select rises before 32 falling edges have been received, the partial frame is dropped and no register changes.
- R3: Address 0 selects channel A and address 1 selects channel B. Address 15 selects both channels. For the channel commands (0 to 3), every other address leaves all registers unchanged.
- R4: Command 0 writes the input register of the addressed channel. It changes the DAC register only if that channel's load-mask bit is set. Command 1 copies the input register of the addressed channel into its DAC register.
- R5: Command 2 writes the input register of the addressed channel. It then loads the DAC registers of all channels from their input registers, including the value just written.
- R6: Command 3 writes both the input register and the DAC register of the addressed channel with the frame code.
- R7: Command 4 sets the power-down flags from code bit 0 (channel A) and code bit 1 (channel B), whatever the address. The register contents of a powered-down channel are kept.
- R8: Command 6 loads the load mask from code bit 0 (A) and code bit 1 (B). While a channel's mask bit is set, command 0 also loads that channel's DAC register.
- R9: Command 5 stores the frame code as the clear code. Command 7 loads the input and DAC registers of both channels with the clear code. It then returns the power-down flags, the load mask, the daisy-chain enable and the clear code to 0.
- R10: Commands 9 to 15 change no state.
- R11: Command 8 sets daisy-chain mode from code bit 0. In this mode the serial output is updated on each rising serial-clock edge with the bit that was shifted in 32 falling edges earlier. A frame is then acted on when frame select rises, provided at least 32 edges were received, and it uses the last 32 bits shifted in. Outside this mode the serial output stays 0.
- R12: Synchronous active-high reset sets both DAC codes, the power-down flags and the serial output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out for daisy-chaining |
| dac_code | output | 32 | DAC register codes; channel A in bits 15:0, channel B in bits 31:16 |
| pwr_dn | output | 2 | Power-down flags; bit 0 is channel A, bit 1 is channel B |

## Verification
A serial edge is first registered by the system clock. Its frame pulse is issued on the next rising clock edge after that. The register update lands on the edge after the pulse, so the DAC codes and power-down flags are due on the second rising edge after the completing serial edge is sampled. The completing edge is the 32nd falling edge in normal mode, or the rise of frame select in daisy-chain mode. The bench model commits its expected state just after that second edge and compares it at every falling system-clock edge. A one-cycle slip in either direction therefore shows up as a mismatch. The serial output is due one rising system-clock edge after the rising serial edge, and it is sampled at the next falling system-clock edge.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
package dacif_pkg;
  localparam int FRAME_W = 32;
  localparam int CMD_LSB = 24;
  localparam int ADR_LSB = 20;
  localparam int DAT_LSB = 4;
  localparam logic [3:0] ADR_ALL = 4'hF;

  typedef enum logic [3:0] {
    CMD_WR_IN      = 4'd0,
    CMD_UPD        = 4'd1,
    CMD_WR_UPD_ALL = 4'd2,
    CMD_WR_UPD     = 4'd3,
    CMD_PWR        = 4'd4,
    CMD_CLR        = 4'd5,
    CMD_MASK       = 4'd6,
    CMD_RST        = 4'd7,
    CMD_DCEN       = 4'd8
  } cmd_e;

  typedef struct packed {
    logic wr_in;
    logic wr_dac;
    logic upd;
    logic ld_clr;
  } chan_ctl_t;
endpackage

// File: rtl/dacif_shift.sv
`timescale 1ns/1ps
module dacif_shift #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_n,
  input  logic          sclk,
  input  logic          sdin,
  input  logic          dcen,
  output logic          frame_vld,
  output logic [FW-1:0] frame,
  output logic          sdo
);
  localparam int CW = $clog2(FW + 1);

  logic          sclk_q, sync_q;
  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;

  wire sclk_fall = sclk_q & ~sclk;
  wire sclk_rise = ~sclk_q & sclk;
  wire sync_rise = ~sync_q & sync_n;
  wire sync_fall = sync_q & ~sync_n;
  wire active    = ~sync_n;
  wire full      = (cnt == CW'(FW));
  wire [FW-1:0] sr_nxt = {sr[FW-2:0], sdin};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      sync_q    <= 1'b1;
      sr        <= '0;
      cnt       <= '0;
      frame_vld <= 1'b0;
      frame     <= '0;
      sdo       <= 1'b0;
    end else begin
      sclk_q    <= sclk;
      sync_q    <= sync_n;
      frame_vld <= 1'b0;
      if (sync_fall) begin
        cnt <= '0;
      end else if (active && sclk_fall && (dcen || !full)) begin
        sr <= sr_nxt;
        if (!full) cnt <= cnt + 1'b1;
        if (!dcen && cnt == CW'(FW - 1)) begin
          frame_vld <= 1'b1;
          frame     <= sr_nxt;
        end
      end
      if (sync_rise && dcen && full) begin
        frame_vld <= 1'b1;
        frame     <= sr;
      end
      if (!dcen)                    sdo <= 1'b0;
      else if (active && sclk_rise) sdo <= sr[FW-1];
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld); // R1
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (sync_rise && !full && !dcen && !sclk_fall) |=> !frame_vld); // R2
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dcen |=> !sdo); // R11
endmodule

// File: rtl/dacif_ctrl.sv
`timescale 1ns/1ps
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_vld,
  input  logic [FRAME_W-1:0]   frame,
  output chan_ctl_t [NCH-1:0]  ctl,
  output logic [DW-1:0]        data,
  output logic [DW-1:0]        clr_code,
  output logic [NCH-1:0]       pd,
  output logic                 dcen
);
  logic [3:0]     cmd, addr;
  logic [NCH-1:0] sel, mask;
  logic           unused_bits;

  assign cmd  = frame[CMD_LSB +: 4];
  assign addr = frame[ADR_LSB +: 4];
  assign data = frame[DAT_LSB +: DW];
  assign unused_bits = ^{frame[FRAME_W-1:CMD_LSB+4], frame[DAT_LSB-1:0]};

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sel[c] = (addr == 4'(c)) || (addr == ADR_ALL);
      ctl[c] = '0;
    end
    if (frame_vld) begin
      for (int c = 0; c < NCH; c++) begin
        case (cmd)
          CMD_WR_IN: begin
            ctl[c].wr_in  = sel[c];
            ctl[c].wr_dac = sel[c] & mask[c];
          end
          CMD_UPD: ctl[c].upd = sel[c];
          CMD_WR_UPD_ALL: if (|sel) begin
            ctl[c].wr_in  = sel[c];
            ctl[c].wr_dac = sel[c];
            ctl[c].upd    = ~sel[c];
          end
          CMD_WR_UPD: begin
            ctl[c].wr_in  = sel[c];
            ctl[c].wr_dac = sel[c];
          end
          CMD_RST: ctl[c].ld_clr = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd       <= '0;
      mask     <= '0;
      dcen     <= 1'b0;
      clr_code <= '0;
    end else if (frame_vld) begin
      case (cmd)
        CMD_PWR:  pd       <= data[NCH-1:0];
        CMD_CLR:  clr_code <= data;
        CMD_MASK: mask     <= data[NCH-1:0];
        CMD_DCEN: dcen     <= data[0];
        CMD_RST: begin
          pd       <= '0;
          mask     <= '0;
          dcen     <= 1'b0;
          clr_code <= '0;
        end
        default: ;
      endcase
    end
  end

  AST_NOP_CMD: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && cmd > 4'd8) |=>
      ($stable(pd) && $stable(mask) && $stable(dcen) && $stable(clr_code))); // R10
  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && cmd == CMD_RST) |=> (pd == '0 && mask == '0 && !dcen)); // R9
endmodule

// File: rtl/dacif_chan.sv
`timescale 1ns/1ps
module dacif_chan
  import dacif_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  chan_ctl_t     ctl,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] clr_code,
  output logic [DW-1:0] dac_q
);
  logic [DW-1:0] in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (ctl.ld_clr)     in_q <= clr_code;
      else if (ctl.wr_in) in_q <= data;
      if (ctl.ld_clr)      dac_q <= clr_code;
      else if (ctl.wr_dac) dac_q <= data;
      else if (ctl.upd)    dac_q <= in_q;
    end
  end

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ctl.wr_dac || ctl.upd || ctl.ld_clr) |=> $stable(dac_q)); // R4
  AST_UPD_COPY: assert property (@(posedge clk) disable iff (rst)
    (ctl.upd && !ctl.wr_dac && !ctl.ld_clr) |=> (dac_q == $past(in_q))); // R4
endmodule

// File: rtl/dacif_top.sv
`timescale 1ns/1ps
module dacif_top
  import dacif_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              sdo,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    pwr_dn
);
  logic                 frame_vld, dcen;
  logic [FRAME_W-1:0]   frame;
  chan_ctl_t [NCH-1:0]  ctl;
  logic [DW-1:0]        data, clr_code;

  dacif_shift #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .dcen(dcen), .frame_vld(frame_vld), .frame(frame), .sdo(sdo)
  );

  dacif_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame(frame),
    .ctl(ctl), .data(data), .clr_code(clr_code), .pd(pwr_dn), .dcen(dcen)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dacif_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst), .ctl(ctl[c]), .data(data),
      .clr_code(clr_code), .dac_q(dac_code[c*DW +: DW])
    );
  end
endmodule

// File: tb/dacif_top_tb.sv
`timescale 1ns/1ps
module dacif_top_tb;
  logic clk = 1'b0, rst = 1'b1, sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic        sdo;
  logic [31:0] dac_code;
  logic [1:0]  pwr_dn;

  int checks = 0, errors = 0;
  bit done = 0, live = 0;

  logic [15:0] m_in [2];
  logic [15:0] m_dac [2];
  logic [1:0]  m_pd, m_mask;
  logic        m_dcen;
  logic [15:0] m_clr;

  always #2.5 clk = ~clk;

  dacif_top u_dut (.clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk),
                   .sdin(sdin), .sdo(sdo), .dac_code(dac_code), .pwr_dn(pwr_dn));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live && !done) begin
    chk("R1 dac_code", dac_code, {m_dac[1], m_dac[0]});
    chk("R7 pwr_dn", {30'd0, pwr_dn}, {30'd0, m_pd});
  end

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    return {4'hA, c, a, d, 4'h5};
  endfunction

  task automatic apply(input logic [31:0] w);
    logic [3:0] c = w[27:24];
    logic [3:0] a = w[23:20];
    logic [15:0] d = w[19:4];
    logic [1:0] s;
    s[0] = (a == 4'd0) || (a == 4'hF);
    s[1] = (a == 4'd1) || (a == 4'hF);
    case (c)
      4'd0: for (int i = 0; i < 2; i++) if (s[i]) begin m_in[i] = d; if (m_mask[i]) m_dac[i] = d; end
      4'd1: for (int i = 0; i < 2; i++) if (s[i]) m_dac[i] = m_in[i];
      4'd2: if (s != 2'b00) begin
              for (int i = 0; i < 2; i++) if (s[i]) m_in[i] = d;
              for (int i = 0; i < 2; i++) m_dac[i] = m_in[i];
            end
      4'd3: for (int i = 0; i < 2; i++) if (s[i]) begin m_in[i] = d; m_dac[i] = d; end
      4'd4: m_pd = d[1:0];
      4'd5: m_clr = d;
      4'd6: m_mask = d[1:0];
      4'd7: begin
              for (int i = 0; i < 2; i++) begin m_in[i] = m_clr; m_dac[i] = m_clr; end
              m_pd = 0; m_mask = 0; m_dcen = 0; m_clr = 0;
            end
      4'd8: m_dcen = d[0];
      default: ;
    endcase
  endtask

  // Shifts n bits (MSB = bits[n-1]) then raises frame select.
  task automatic send(input logic [63:0] bits, input int n);
    logic dc = m_dcen;
    @(negedge clk) sync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; sdin = bits[n-1-i];
      @(negedge clk);
      if (dc && i >= 32) chk("R11 sdo", {31'd0, sdo}, {31'd0, bits[n-1-(i-32)]});
      @(negedge clk) sclk = 1'b0;
      if (!dc && i == 31) begin
        @(posedge clk); @(posedge clk); #1 apply(bits[n-1 -: 32]);
      end
      @(negedge clk); @(negedge clk);
    end
    sync_n = 1'b1;
    if (dc && n >= 32) begin
      @(posedge clk); @(posedge clk); #1 apply(bits[31:0]);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic frame32(input logic [31:0] w);
    send({32'd0, w}, 32);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_in[i] = 0; m_dac[i] = 0; end
    m_pd = 0; m_mask = 0; m_dcen = 0; m_clr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset dac", dac_code, 32'd0);
    chk("R12 reset pd", {30'd0, pwr_dn}, 32'd0);
    chk("R12 reset sdo", {31'd0, sdo}, 32'd0);
    live = 1;

    frame32(mk(4'd3, 4'd0, 16'h1234));
    chk("R6 write+load A", dac_code, 32'h0000_1234);
    frame32(mk(4'd0, 4'd1, 16'hBEEF));
    chk("R4 staged write leaves B", dac_code, 32'h0000_1234);
    frame32(mk(4'd1, 4'd1, 16'h0000));
    chk("R4 update B", dac_code, 32'hBEEF_1234);
    frame32(mk(4'd0, 4'hF, 16'h0F0F));
    frame32(mk(4'd2, 4'd0, 16'hFFFF));
    chk("R5 write A update all", dac_code, 32'h0F0F_FFFF);
    frame32(mk(4'd3, 4'd5, 16'h7777));
    chk("R3 reserved address", dac_code, 32'h0F0F_FFFF);
    frame32(mk(4'd3, 4'hF, 16'h0001));
    chk("R3 both channels", dac_code, 32'h0001_0001);

    send({32'd0, mk(4'd3, 4'd0, 16'h5555)} >> 12, 20);
    chk("R2 aborted frame", dac_code, 32'h0001_0001);
    frame32(mk(4'd3, 4'd0, 16'h5555));
    chk("R2 next frame ok", dac_code, 32'h0001_5555);

    frame32(mk(4'd4, 4'd7, 16'h0002));
    chk("R7 power down B", {30'd0, pwr_dn}, 32'd2);
    chk("R7 codes kept", dac_code, 32'h0001_5555);
    frame32(mk(4'd4, 4'd0, 16'h0001));
    chk("R7 power down A", {30'd0, pwr_dn}, 32'd1);

    frame32(mk(4'd6, 4'd0, 16'h0001));
    frame32(mk(4'd0, 4'd0, 16'hAAAA));
    chk("R8 masked A loads", dac_code, 32'h0001_AAAA);
    frame32(mk(4'd0, 4'd1, 16'hCCCC));
    chk("R8 unmasked B holds", dac_code, 32'h0001_AAAA);

    for (int c = 9; c < 16; c++) begin
      frame32(mk(4'(c), 4'hF, 16'hFFFF));
      chk("R10 no-op command", dac_code, 32'h0001_AAAA);
      chk("R10 no-op pd", {30'd0, pwr_dn}, 32'd1);
    end

    frame32(mk(4'd5, 4'd0, 16'h4321));
    frame32(mk(4'd7, 4'd0, 16'h0000));
    chk("R9 reset loads clear code", dac_code, 32'h4321_4321);
    chk("R9 reset clears pd", {30'd0, pwr_dn}, 32'd0);
    frame32(mk(4'd0, 4'd0, 16'h1111));
    chk("R9 mask cleared", dac_code, 32'h4321_4321);
    frame32(mk(4'd7, 4'd0, 16'h0000));
    chk("R9 clear code cleared", dac_code, 32'h0000_0000);

    frame32(mk(4'd8, 4'd0, 16'h0001));
    send({mk(4'd3, 4'd1, 16'h2222), mk(4'd3, 4'd0, 16'h3333)}, 64);
    chk("R11 last 32 bits used", dac_code, 32'h0000_3333);
    send({32'd0, mk(4'd8, 4'd0, 16'h0000)}, 32);
    chk("R11 daisy off sdo", {31'd0, sdo}, 32'd0);
    frame32(mk(4'd3, 4'd1, 16'h9876));
    chk("R1 normal mode again", dac_code, 32'h9876_3333);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule